// File: doc/BRIEF.md
# CAN Transmit Buffer Request Scheduler

This block holds the control and status bits for a set of CAN message buffers (eight by default) and decides which one the protocol engine sends next. Software reaches the buffers through 16-bit registers. Each register covers two buffers: register k holds buffer 2k in its low byte and buffer 2k+1 in its high byte. Each buffer is either a transmit or a receive buffer. Software sets a send request and a two-bit priority on a buffer. It can withdraw a request to abort the send, and it can enable an automatic reply when a remote frame arrives for that buffer.

The scheduler looks at every transmit buffer that has a pending request. It offers the one with the highest priority to the engine as a valid flag plus a buffer index. When the engine starts a frame, it pulses a start input, and the block latches the offered index as the frame in flight. When the frame ends, the engine pulses done with a result code. The block then clears the request, or records lost arbitration or a bus error and leaves the request set so the buffer competes again. An abort that software asks for while that buffer's frame is on the wire is held back until the end of that frame.

Top module: `can_txreq_sched`

## Requirements
- R1: After reset every register reads 0 and tx_valid is 0.
- R2: Register k holds buffer 2k in bits 7..0 and buffer 2k+1 in bits 15..8. Each byte is laid out as: bit 7 transmit-enable, bit 6 aborted, bit 5 lost-arbitration, bit 4 bus-error, bit 3 send-request, bit 2 auto-remote-enable, bits 1..0 priority. Writes to bits 6..4 have no effect.
- R3: Writing 1 to send-request of a buffer whose transmit-enable is 1 makes that buffer a candidate. tx_valid and tx_idx show the result from the clock edge after the write.
- R4: Among candidates, the buffer with the largest priority value wins (11 highest, 00 lowest), and ties go to the lowest index. A buffer whose transmit-enable is 0 is never offered.
- R5: An end-of-frame report with result 00 (success) for the frame in flight clears that buffer's send-request and leaves the aborted flag at 0.
- R6: Writing 0 to send-request while it is 1, on a buffer that is not in flight, clears send-request and sets aborted at the same edge.
- R7: Writing 0 to send-request of the buffer in flight leaves send-request at 1 until the end-of-frame report. At that report send-request clears. Aborted is set if the result was a failure and stays 0 if the result was success.
- R8: Result 01 sets lost-arbitration, and result 10 or 11 sets bus-error, in both cases with send-request left at 1. Each flag stays set through later frames until software next sets send-request.
- R9: Any write of 1 to send-request clears aborted, lost-arbitration and bus-error.
- R10: A remote-frame pulse for buffer i sets its send-request and clears its three flags if auto-remote-enable is 1. If auto-remote-enable is 0 the buffer is left unchanged.
- R11: eng_start is ignored while a frame is in flight or while tx_valid is 0. eng_done is ignored while no frame is in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register index for the write |
| wr_data | input | 16 | Write data, two buffer bytes |
| rd_addr | input | 2 | Register index for the read |
| rd_data | output | 16 | Combinational readback of the addressed register |
| tx_valid | output | 1 | A candidate buffer is available |
| tx_idx | output | 3 | Index of the offered buffer |
| eng_start | input | 1 | Engine begins sending the offered buffer |
| eng_done | input | 1 | Engine reports end of the frame in flight |
| eng_res | input | 2 | Result of the frame: 00 success, 01 lost arbitration, 1x bus error |
| rmt_hit | input | 1 | A remote frame was received |
| rmt_idx | input | 3 | Buffer index the remote frame matched |

## Verification
Selection is driven from a table of priority, transmit-enable and request masks. Some entries have no candidate at all. Some have all-equal priorities, which shows the lowest-index tie rule. In others a single high-priority buffer sits among low ones, which shows that priority outranks index. One entry gives a receive buffer the top priority, to show that transmit-enable really filters the candidates. Directed sequences then separate the outcomes that look alike: an abort on an idle buffer against one on a frame in flight, a failed frame against a successful one under a pending abort, and lost arbitration against a bus error. They also show that a flag persists across a later successful frame, that a remote frame arriving on a buffer with auto-reply enabled behaves differently from one with it disabled, and that an end-of-frame report with nothing in flight changes nothing.

// File: rtl/can_txs_pkg.sv
package can_txs_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned PRI_W  = 2;
   localparam int unsigned F_TXEN = 7;
   localparam int unsigned F_ABT  = 6;
   localparam int unsigned F_LOST = 5;
   localparam int unsigned F_BERR = 4;
   localparam int unsigned F_REQ  = 3;
   localparam int unsigned F_RTR  = 2;

   typedef enum logic [1:0] {
      RES_OK   = 2'b00,
      RES_LOST = 2'b01,
      RES_BERR = 2'b10,
      RES_BER2 = 2'b11
   } eng_res_e;
endpackage

// File: rtl/can_txs_slot.sv
module can_txs_slot
   import can_txs_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [BYTE_W-1:0] wr_byte,
   input  logic              in_flight,
   input  logic              done_hit,
   input  logic [1:0]        res,
   input  logic              rmt_hit,
   output logic [BYTE_W-1:0] st_byte
);
   logic             txen_q, rtr_q, req_q, abt_q, lost_q, berr_q, apend_q;
   logic [PRI_W-1:0] pri_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         txen_q  <= 1'b0;
         rtr_q   <= 1'b0;
         req_q   <= 1'b0;
         abt_q   <= 1'b0;
         lost_q  <= 1'b0;
         berr_q  <= 1'b0;
         apend_q <= 1'b0;
         pri_q   <= '0;
      end else if (wr_hit) begin
         txen_q <= wr_byte[F_TXEN];
         rtr_q  <= wr_byte[F_RTR];
         pri_q  <= wr_byte[PRI_W-1:0];
         if (wr_byte[F_REQ]) begin
            req_q   <= 1'b1;
            abt_q   <= 1'b0;
            lost_q  <= 1'b0;
            berr_q  <= 1'b0;
            apend_q <= 1'b0;
         end else if (req_q) begin
            if (in_flight) begin
               apend_q <= 1'b1;
            end else begin
               req_q <= 1'b0;
               abt_q <= 1'b1;
            end
         end
      end else if (done_hit) begin
         apend_q <= 1'b0;
         unique case (eng_res_e'(res))
            RES_OK: req_q <= 1'b0;
            RES_LOST: begin
               lost_q <= 1'b1;
               if (apend_q) begin
                  req_q <= 1'b0;
                  abt_q <= 1'b1;
               end
            end
            default: begin
               berr_q <= 1'b1;
               if (apend_q) begin
                  req_q <= 1'b0;
                  abt_q <= 1'b1;
               end
            end
         endcase
      end else if (rmt_hit && rtr_q) begin
         req_q   <= 1'b1;
         abt_q   <= 1'b0;
         lost_q  <= 1'b0;
         berr_q  <= 1'b0;
         apend_q <= 1'b0;
      end
   end

   always_comb begin
      st_byte                 = '0;
      st_byte[F_TXEN]         = txen_q;
      st_byte[F_ABT]          = abt_q;
      st_byte[F_LOST]         = lost_q;
      st_byte[F_BERR]         = berr_q;
      st_byte[F_REQ]          = req_q;
      st_byte[F_RTR]          = rtr_q;
      st_byte[PRI_W-1:0]      = pri_q;
   end

   // R9: a request that just rose carries no stale status
   assert_set_clears_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_q) |-> (!abt_q && !lost_q && !berr_q));
   // R6 / R7: an abort always leaves the request withdrawn
   assert_abort_drops_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(abt_q) |-> !req_q);
   // R7: a deferred abort exists only for a live request
   assert_defer_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      apend_q |-> req_q);
   // R8: a retry outcome keeps the request set
   assert_retry_keeps_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_hit && !wr_hit && !apend_q && res != 2'b00) |=> req_q);
endmodule

// File: rtl/can_txs_arb.sv
module can_txs_arb
   import can_txs_pkg::*;
#(
   parameter int unsigned NUM_BUF  = 8,
   parameter bit          LOW_WINS = 1'b1,
   localparam int unsigned IDX_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_BUF-1:0]             elig,
   input  logic [NUM_BUF-1:0][PRI_W-1:0]  pri,
   output logic                           sel_v,
   output logic [IDX_W-1:0]               sel_idx
);
   logic [PRI_W-1:0] best_p;

   generate
      if (LOW_WINS) begin : g_low
         always_comb begin
            sel_v   = 1'b0;
            sel_idx = '0;
            best_p  = '0;
            for (int i = 0; i < NUM_BUF; i++) begin
               if (elig[i] && (!sel_v || pri[i] > best_p)) begin
                  sel_v   = 1'b1;
                  sel_idx = IDX_W'(i);
                  best_p  = pri[i];
               end
            end
         end
      end else begin : g_high
         always_comb begin
            sel_v   = 1'b0;
            sel_idx = '0;
            best_p  = '0;
            for (int i = 0; i < NUM_BUF; i++) begin
               if (elig[i] && (!sel_v || pri[i] >= best_p)) begin
                  sel_v   = 1'b1;
                  sel_idx = IDX_W'(i);
                  best_p  = pri[i];
               end
            end
         end
      end
   endgenerate

   // R3 / R4: the offered buffer is a real candidate
   assert_sel_eligible_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sel_v |-> elig[sel_idx]);
   // R3: nothing offered only when nothing pending
   assert_idle_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_v |-> ($countones(elig) == 0));

   generate
      for (genvar j = 0; j < NUM_BUF; j++) begin : g_rank
         // R4: no candidate outranks the offered one
         assert_rank_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_v && elig[j]) |-> (pri[j] <= pri[sel_idx]));
      end
   endgenerate
endmodule

// File: rtl/can_txs_track.sv
module can_txs_track #(
   parameter int unsigned NUM_BUF = 8,
   localparam int unsigned IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel_v,
   input  logic [IDX_W-1:0]   sel_idx,
   input  logic               eng_start,
   input  logic               eng_done,
   output logic [NUM_BUF-1:0] flight,
   output logic [NUM_BUF-1:0] done_hit
);
   logic             act_q;
   logic [IDX_W-1:0] act_idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q     <= 1'b0;
         act_idx_q <= '0;
      end else if (act_q && eng_done) begin
         act_q <= 1'b0;
      end else if (!act_q && eng_start && sel_v) begin
         act_q     <= 1'b1;
         act_idx_q <= sel_idx;
      end
   end

   generate
      for (genvar i = 0; i < NUM_BUF; i++) begin : g_hit
         assign flight[i]   = act_q && (act_idx_q == IDX_W'(i)) && !eng_done;
         assign done_hit[i] = act_q && (act_idx_q == IDX_W'(i)) && eng_done;
      end
   endgenerate

   // R11: the frame in flight keeps its index until its end is reported
   assert_idx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && !eng_done) |=> (act_q && $stable(act_idx_q)));
   // R11: at most one buffer is in flight
   assert_one_flight_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(done_hit | flight));
endmodule

// File: rtl/can_txreq_sched.sv
module can_txreq_sched
   import can_txs_pkg::*;
#(
   parameter int unsigned NUM_BUF  = 8,
   parameter bit          LOW_WINS = 1'b1,
   localparam int unsigned IDX_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
   localparam int unsigned NUM_REG = NUM_BUF / 2,
   localparam int unsigned ADDR_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1,
   localparam int unsigned REG_W   = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [REG_W-1:0]  rd_data,
   output logic              tx_valid,
   output logic [IDX_W-1:0]  tx_idx,
   input  logic              eng_start,
   input  logic              eng_done,
   input  logic [1:0]        eng_res,
   input  logic              rmt_hit,
   input  logic [IDX_W-1:0]  rmt_idx
);
   initial begin
      assert (NUM_BUF >= 2 && (NUM_BUF % 2) == 0)
         else $error("NUM_BUF must be even and at least 2");
   end

   logic [NUM_BUF-1:0][BYTE_W-1:0] st;
   logic [NUM_BUF-1:0][PRI_W-1:0]  pri;
   logic [NUM_BUF-1:0]             elig, flight, done_hit;

   generate
      for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
         logic [BYTE_W-1:0] byte_in;
         assign byte_in = (i % 2 == 1) ? wr_data[REG_W-1:BYTE_W] : wr_data[BYTE_W-1:0];

         can_txs_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_hit    (wr_en && (wr_addr == ADDR_W'(i / 2))),
            .wr_byte   (byte_in),
            .in_flight (flight[i]),
            .done_hit  (done_hit[i]),
            .res       (eng_res),
            .rmt_hit   (rmt_hit && (rmt_idx == IDX_W'(i))),
            .st_byte   (st[i])
         );

         assign elig[i] = st[i][F_TXEN] && st[i][F_REQ];
         assign pri[i]  = st[i][PRI_W-1:0];
      end
   endgenerate

   can_txs_arb #(.NUM_BUF(NUM_BUF), .LOW_WINS(LOW_WINS)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .elig    (elig),
      .pri     (pri),
      .sel_v   (tx_valid),
      .sel_idx (tx_idx)
   );

   can_txs_track #(.NUM_BUF(NUM_BUF)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_v     (tx_valid),
      .sel_idx   (tx_idx),
      .eng_start (eng_start),
      .eng_done  (eng_done),
      .flight    (flight),
      .done_hit  (done_hit)
   );

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NUM_REG; k++) begin
         if (rd_addr == ADDR_W'(k)) rd_data = {st[2*k+1], st[2*k]};
      end
   end

   // R1: nothing is offered in the cycle after reset
   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> !tx_valid);
endmodule

// File: tb/can_txreq_sched_bench.sv
`timescale 1ns/1ps
module can_txreq_sched_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        tx_valid;
   logic [2:0]  tx_idx;
   logic        eng_start = 1'b0;
   logic        eng_done = 1'b0;
   logic [1:0]  eng_res = '0;
   logic        rmt_hit = 1'b0;
   logic [2:0]  rmt_idx = '0;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   can_txreq_sched u_can_txreq_sched (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .tx_valid(tx_valid), .tx_idx(tx_idx),
      .eng_start(eng_start), .eng_done(eng_done), .eng_res(eng_res),
      .rmt_hit(rmt_hit), .rmt_idx(rmt_idx));

   // {prio[15:0] buf7..buf0, txen[7:0], req[7:0], exp_valid, exp_idx[2:0]}
   localparam logic [35:0] VEC [9] = '{
      {16'h0000, 8'hFF, 8'h00, 1'b0, 3'd0},
      {16'h0000, 8'hFF, 8'h24, 1'b1, 3'd2},
      {16'h0C00, 8'hFF, 8'h24, 1'b1, 3'd5},
      {16'h5555, 8'hFF, 8'hFF, 1'b1, 3'd0},
      {16'hC000, 8'h7F, 8'hFF, 1'b1, 3'd0},
      {16'hA000, 8'hC0, 8'hC0, 1'b1, 3'd6},
      {16'h0000, 8'hF0, 8'h0F, 1'b0, 3'd0},
      {16'h4000, 8'h81, 8'h81, 1'b1, 3'd7},
      {16'h1280, 8'hFF, 8'hFF, 1'b1, 3'd3}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      rd_addr = a; #0.5; d = rd_data;
   endtask

   task automatic start();
      @(negedge clk); eng_start = 1'b1;
      @(negedge clk); eng_start = 1'b0;
   endtask

   task automatic done(input logic [1:0] r);
      @(negedge clk); eng_done = 1'b1; eng_res = r;
      @(negedge clk); eng_done = 1'b0; eng_res = 2'b00;
   endtask

   task automatic remote(input logic [2:0] i);
      @(negedge clk); rmt_hit = 1'b1; rmt_idx = i;
      @(negedge clk); rmt_hit = 1'b0;
   endtask

   initial begin
      #(5.0 * 150000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] v;
      do_reset();
      // R1: reset state
      for (int k = 0; k < 4; k++) begin
         rd(2'(k), v);
         check("R1 reg after reset", 32'(v), 32'h0);
      end
      check("R1 tx_valid after reset", 32'(tx_valid), 32'h0);

      // R4 / R3: arbitration table
      for (int e = 0; e < 9; e++) begin
         for (int k = 0; k < 4; k++) begin
            logic [7:0] lo, hi;
            lo = {VEC[e][12 + 2*k], 3'b000, VEC[e][4 + 2*k], 1'b0, VEC[e][20 + 4*k +: 2]};
            hi = {VEC[e][13 + 2*k], 3'b000, VEC[e][5 + 2*k], 1'b0, VEC[e][22 + 4*k +: 2]};
            wr(2'(k), {hi, lo});
         end
         check("R4 table valid", 32'(tx_valid), 32'(VEC[e][3]));
         if (VEC[e][3]) check("R4 table index", 32'(tx_idx), 32'(VEC[e][2:0]));
      end

      do_reset();
      // R3 / R2: both bytes of register 0, readback of full layout
      wr(2'd0, 16'hFFFF);
      rd(2'd0, v);
      check("R2 readback with status bits ignored", 32'(v), 32'h8F8F);
      check("R3 valid after request", 32'(tx_valid), 32'h1);
      check("R3 index after request", 32'(tx_idx), 32'h0);

      // R5: successful frame clears request
      start();
      done(2'b00);
      rd(2'd0, v);
      check("R5 success clears request", 32'(v), 32'h8F87);
      check("R5 next buffer offered", 32'(tx_idx), 32'h1);

      // R6: abort on idle buffer 1
      wr(2'd0, 16'h8787);
      rd(2'd0, v);
      check("R6 idle abort", 32'(v), 32'hC787);
      check("R6 nothing offered", 32'(tx_valid), 32'h0);

      // R2: status bit write has no effect
      wr(2'd0, 16'h0787);
      rd(2'd0, v);
      check("R2 aborted flag not writable", 32'(v), 32'h4787);

      // R9: setting request clears flags
      wr(2'd0, 16'h8F87);
      rd(2'd0, v);
      check("R9 flags cleared on request", 32'(v), 32'h8F87);

      // R7: abort in flight, frame succeeds
      start();
      wr(2'd0, 16'h8787);
      rd(2'd0, v);
      check("R7 request held while in flight", 32'(v), 32'h8F87);
      done(2'b00);
      rd(2'd0, v);
      check("R7 deferred abort on success", 32'(v), 32'h8787);

      // R7: abort in flight, frame loses arbitration
      wr(2'd0, 16'h8F87);
      start();
      wr(2'd0, 16'h8787);
      done(2'b01);
      rd(2'd0, v);
      check("R7 deferred abort on failure", 32'(v), 32'hE787);

      // R8: lost arbitration then bus error then success on buffer 2
      wr(2'd1, 16'h008A);
      check("R3 buffer 2 offered", 32'(tx_idx), 32'h2);
      start();
      done(2'b01);
      rd(2'd1, v);
      check("R8 lost arbitration keeps request", 32'(v), 32'h00AA);
      check("R8 buffer still offered", 32'(tx_idx), 32'h2);
      start();
      done(2'b10);
      rd(2'd1, v);
      check("R8 bus error added", 32'(v), 32'h00BA);
      start();
      done(2'b00);
      rd(2'd1, v);
      check("R8 flags persist after success", 32'(v), 32'h00B2);

      // R10: remote frames
      wr(2'd2, 16'h8480);
      remote(3'd5);
      rd(2'd2, v);
      check("R10 remote sets request", 32'(v), 32'h8C80);
      check("R10 remote buffer offered", 32'(tx_idx), 32'h5);
      remote(3'd4);
      rd(2'd2, v);
      check("R10 remote ignored without enable", 32'(v), 32'h8C80);

      // R11: end-of-frame with nothing in flight
      done(2'b00);
      rd(2'd2, v);
      check("R11 stray done ignored", 32'(v), 32'h8C80);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule